// File: doc/BRIEF.md
# Completion Queue Index Manager

This block keeps the ring indexes for two completion rings of a network controller: one for receive completions and one for transmit completions. The datapath posts a completion into a ring. The block writes the entry into a small internal entry RAM at the ring's producer index, then advances that producer index. Host software reads the indexes through a two-register port, fetches the entries through a one-cycle read port, and returns them by writing a new consumer index.

The two rings share each index register. The receive ring uses one half and the transmit ring uses the other. Per-half write enables let software move one ring without touching the other. A registered `pending` flag tells the host that at least one ring still holds entries it has not consumed.

A ring refuses a post while it is full, that is when one more entry would make the producer index equal to the consumer index. The refusal sets a sticky overflow flag for that ring. Receive entries carry a status bit, a frame length and a buffer index. Transmit entries carry a status bit and the buffer position as a byte offset, which the block derives from a position counted in 8-byte blocks.

Top module: `cq_index_mgr`

## Requirements
- R1: While `rst` is held and after it is released, both rings' producer and consumer indexes are 0, and `pending`, `rx_ovf` and `tx_ovf` are 0.
- R2: `reg_rdata` shows, one cycle after the cycle it is selected, the consumer indexes when `reg_sel`=0 or the producer indexes when `reg_sel`=1. The receive index sits in bits 15:0 and the transmit index in bits 31:16, each zero-extended. On a write, only the low log2(DEPTH) bits of each 16-bit half are kept.
- R3: A register write updates the receive half only if `reg_be[0]` is set and the transmit half only if `reg_be[1]` is set. The other half keeps its stored value.
- R4: A post that is accepted advances that ring's producer index by one, wrapping from DEPTH-1 to 0.
- R5: A post that arrives while (producer+1) mod DEPTH equals the consumer index is refused. The producer index and the entry RAM stay unchanged, and the ring's overflow flag (`rx_ovf` or `tx_ovf`) is set and stays set until reset.
- R6: An accepted receive post stores, at the old producer index, the word {ok in bit 31, length in bits 30:16, buffer index in bits 15:0}.
- R7: An accepted transmit post stores, at the old producer index, the word {ok in bit 31, zeros in bits 30:16, block position × 8 in bits 15:0}.
- R8: A post and a consumer-register write to the same ring in the same cycle both take effect. A producer-register write to a ring in the same cycle as a post to that ring wins: the post is dropped, with no entry write and no overflow.
- R9: `pending` equals, one cycle after, the OR over both rings of (consumer index ≠ producer index).
- R10: A request on `ent_rd_en` returns the entry at `ent_rd_idx` on `ent_rd_data` in the next cycle, from the receive ring when `ent_rd_ring`=0 and from the transmit ring when it is 1.
- R11: Writing 0 to both halves of both index registers empties both rings, and `pending` then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Index register write strobe |
| reg_sel | input | 1 | 0 = consumer register, 1 = producer register |
| reg_be | input | 2 | Half enables: bit 0 receive, bit 1 transmit |
| reg_wdata | input | 32 | Write data, receive index in 15:0, transmit in 31:16 |
| reg_rdata | output | 32 | Registered read data of the selected register |
| rx_post | input | 1 | Receive completion post |
| rx_post_ok | input | 1 | Receive status-OK bit |
| rx_post_len | input | 15 | Received frame length |
| rx_post_buf | input | 16 | Index of the buffer descriptor used |
| tx_post | input | 1 | Transmit completion post |
| tx_post_ok | input | 1 | Transmit status-OK bit |
| tx_post_blk | input | 13 | Descriptor position in 8-byte blocks |
| ent_rd_en | input | 1 | Entry read request |
| ent_rd_ring | input | 1 | Entry ring select: 0 receive, 1 transmit |
| ent_rd_idx | input | log2(DEPTH) | Entry index to read |
| ent_rd_data | output | 32 | Entry read data, one cycle after the request |
| pending | output | 1 | Registered: some ring has unconsumed entries |
| rx_ovf | output | 1 | Sticky receive ring overflow |
| tx_ovf | output | 1 | Sticky transmit ring overflow |

## Verification
The embedded assertions check on every cycle the following properties:
- the producer step and its wrap;
- the refusal of a post into a full ring;
- the stickiness of the overflow flags;
- that an index never moves without a cause;
- that a producer write wins over a post;
- the one-cycle lag of `pending`.

Only the bench's scenarios can show other properties:
- the entry word layouts and the byte-offset scaling;
- the half-register merge, as seen through readback;
- index truncation;
- the entry read path;
- the emptying sequence.

The bench runs these scenarios over every fill level of an 8-deep ring.

// File: rtl/cqim_pkg.sv
package cqim_pkg;
  localparam int HALF_W    = 16;
  localparam int WORD_W    = 32;
  localparam int RX_LEN_W  = 15;
  localparam int TX_BLK_W  = 13;
  localparam int BLK_SHIFT = 3;

  function automatic logic [WORD_W-1:0] rx_entry(input logic ok,
                                                 input logic [RX_LEN_W-1:0] len,
                                                 input logic [HALF_W-1:0] bidx);
    return {ok, len, bidx};
  endfunction

  // byte offset = block position scaled by the 8-byte block size
  function automatic logic [WORD_W-1:0] tx_entry(input logic ok,
                                                 input logic [TX_BLK_W-1:0] blk);
    return {ok, {(WORD_W-1-HALF_W){1'b0}}, blk, {BLK_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/cqim_entry_ram.sv
module cqim_entry_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cqim_ring.sv
module cqim_ring
  import cqim_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post,
  input  logic [WORD_W-1:0] post_word,
  input  logic              cons_wr,
  input  logic [IDX_W-1:0]  cons_wdata,
  input  logic              prod_wr,
  input  logic [IDX_W-1:0]  prod_wdata,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  cons,
  output logic [IDX_W-1:0]  prod,
  output logic              ovf,
  output logic              not_empty,
  output logic [WORD_W-1:0] rd_data
);
  typedef logic [IDX_W-1:0] idx_t;

  idx_t prod_q, cons_q;
  logic ovf_q;
  logic full, accept, refuse;

  assign full   = (idx_t'(prod_q + 1'b1) == cons_q);
  assign accept = post && !prod_wr && !full;
  assign refuse = post && !prod_wr && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      cons_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (prod_wr)     prod_q <= prod_wdata;
      else if (accept) prod_q <= prod_q + 1'b1;
      if (cons_wr)     cons_q <= cons_wdata;
      if (refuse)      ovf_q  <= 1'b1;
    end
  end

  cqim_entry_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (prod_q),
    .wdata (post_word),
    .re    (rd_en),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  assign cons      = cons_q;
  assign prod      = prod_q;
  assign ovf       = ovf_q;
  assign not_empty = (cons_q != prod_q);

  // R4
  post_step_chk: assert property (@(posedge clk) disable iff (rst)
    (post && !prod_wr && !full) |=> prod_q == idx_t'($past(prod_q) + 1'b1));
  // R5
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (post && !prod_wr && full) |=> ($stable(prod_q) && ovf_q));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R3
  cons_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cons_wr |=> $stable(cons_q));
  // R8
  prod_wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    prod_wr |=> prod_q == $past(prod_wdata));
  // R4
  prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!post && !prod_wr) |=> $stable(prod_q));
endmodule

// File: rtl/cq_index_mgr.sv
module cq_index_mgr
  import cqim_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_sel,
  input  logic [1:0]               reg_be,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     rx_post,
  input  logic                     rx_post_ok,
  input  logic [14:0]              rx_post_len,
  input  logic [15:0]              rx_post_buf,
  input  logic                     tx_post,
  input  logic                     tx_post_ok,
  input  logic [12:0]              tx_post_blk,
  input  logic                     ent_rd_en,
  input  logic                     ent_rd_ring,
  input  logic [$clog2(DEPTH)-1:0] ent_rd_idx,
  output logic [31:0]              ent_rd_data,
  output logic                     pending,
  output logic                     rx_ovf,
  output logic                     tx_ovf
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int NRINGS = 2;   // ring 0 receive, ring 1 transmit

  typedef logic [IDX_W-1:0] idx_t;

  logic [NRINGS-1:0] ring_post, ring_cons_wr, ring_prod_wr, ring_rd, ring_ne, ring_ovf;
  logic [WORD_W-1:0] ring_word [NRINGS];
  logic [WORD_W-1:0] ring_rdata [NRINGS];
  idx_t              ring_cons [NRINGS];
  idx_t              ring_prod [NRINGS];
  idx_t              ring_wval [NRINGS];
  logic              rd_ring_q;
  logic              unused_wdata;

  assign ring_post    = {tx_post, rx_post};
  assign ring_word[0] = rx_entry(rx_post_ok, rx_post_len, rx_post_buf);
  assign ring_word[1] = tx_entry(tx_post_ok, tx_post_blk);
  assign unused_wdata = ^reg_wdata;

  for (genvar k = 0; k < NRINGS; k++) begin : g_ring
    assign ring_cons_wr[k] = reg_wr && !reg_sel && reg_be[k];
    assign ring_prod_wr[k] = reg_wr &&  reg_sel && reg_be[k];
    assign ring_rd[k]      = ent_rd_en && (ent_rd_ring == k[0]);
    assign ring_wval[k]    = idx_t'(reg_wdata[k*HALF_W +: HALF_W]);

    cqim_ring #(.DEPTH(DEPTH)) u_ring (
      .clk        (clk),
      .rst        (rst),
      .post       (ring_post[k]),
      .post_word  (ring_word[k]),
      .cons_wr    (ring_cons_wr[k]),
      .cons_wdata (ring_wval[k]),
      .prod_wr    (ring_prod_wr[k]),
      .prod_wdata (ring_wval[k]),
      .rd_en      (ring_rd[k]),
      .rd_idx     (ent_rd_idx),
      .cons       (ring_cons[k]),
      .prod       (ring_prod[k]),
      .ovf        (ring_ovf[k]),
      .not_empty  (ring_ne[k]),
      .rd_data    (ring_rdata[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      reg_rdata <= '0;
      rd_ring_q <= 1'b0;
    end else begin
      pending   <= |ring_ne;
      reg_rdata <= reg_sel ? {HALF_W'(ring_prod[1]), HALF_W'(ring_prod[0])}
                           : {HALF_W'(ring_cons[1]), HALF_W'(ring_cons[0])};
      if (ent_rd_en) rd_ring_q <= ent_rd_ring;
    end
  end

  assign ent_rd_data = rd_ring_q ? ring_rdata[1] : ring_rdata[0];
  assign rx_ovf      = ring_ovf[0];
  assign tx_ovf      = ring_ovf[1];

  // R9
  pending_lag_chk: assert property (@(posedge clk) disable iff (rst)
    pending == $past(|ring_ne));
  // R1
  reset_idx_chk: assert property (@(posedge clk)
    $past(rst) |-> (ring_cons[0] == '0 && ring_prod[0] == '0 && !pending));
endmodule

// File: tb/sim_cq_index_mgr.sv
`timescale 1ns/1ps
module sim_cq_index_mgr;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [1:0]  reg_be = 2'b00;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rx_post = 1'b0, rx_post_ok = 1'b0;
  logic [14:0] rx_post_len = '0;
  logic [15:0] rx_post_buf = '0;
  logic        tx_post = 1'b0, tx_post_ok = 1'b0;
  logic [12:0] tx_post_blk = '0;
  logic        ent_rd_en = 1'b0, ent_rd_ring = 1'b0;
  logic [2:0]  ent_rd_idx = '0;
  logic [31:0] ent_rd_data;
  logic        pending, rx_ovf, tx_ovf;

  int vectors = 0, fails = 0;
  bit done = 0;
  int exp_prod [2], exp_cons [2];
  bit exp_ovf [2];
  logic [31:0] exp_mem [2][D];

  always #2 clk = ~clk;

  cq_index_mgr #(.DEPTH(D)) u0 (
    .clk, .rst, .reg_wr, .reg_sel, .reg_be, .reg_wdata, .reg_rdata,
    .rx_post, .rx_post_ok, .rx_post_len, .rx_post_buf,
    .tx_post, .tx_post_ok, .tx_post_blk,
    .ent_rd_en, .ent_rd_ring, .ent_rd_idx, .ent_rd_data,
    .pending, .rx_ovf, .tx_ovf
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    for (int k = 0; k < 2; k++) begin
      exp_prod[k] = 0; exp_cons[k] = 0; exp_ovf[k] = 0;
    end
  endtask

  // one clock of stimulus plus the model update derived from the requirements
  task automatic step(input logic rp, input logic rok, input logic [14:0] rlen,
                      input logic [15:0] rbuf, input logic tp, input logic tok,
                      input logic [12:0] tblk, input logic wr, input logic sel,
                      input logic [1:0] be, input logic [31:0] wd);
    logic [31:0] w [2];
    logic p [2];
    int half;
    w[0] = {rok, rlen, rbuf};
    w[1] = {tok, 15'd0, 16'(tblk * 8)};
    p[0] = rp; p[1] = tp;
    for (int k = 0; k < 2; k++) begin
      half = int'((wd >> (16 * k)) & 32'hFFFF);
      if (wr && sel && be[k]) exp_prod[k] = half % D;
      else if (p[k]) begin
        if ((exp_prod[k] + 1) % D == exp_cons[k]) exp_ovf[k] = 1;
        else begin
          exp_mem[k][exp_prod[k]] = w[k];
          exp_prod[k] = (exp_prod[k] + 1) % D;
        end
      end
      if (wr && !sel && be[k]) exp_cons[k] = half % D;
    end
    rx_post = rp; rx_post_ok = rok; rx_post_len = rlen; rx_post_buf = rbuf;
    tx_post = tp; tx_post_ok = tok; tx_post_blk = tblk;
    reg_wr = wr; reg_sel = sel; reg_be = be; reg_wdata = wd;
    tick();
    rx_post = 1'b0; tx_post = 1'b0; reg_wr = 1'b0; reg_be = 2'b00;
  endtask

  task automatic wreg(input logic sel, input logic [1:0] be, input logic [31:0] wd);
    step(0, 0, '0, '0, 0, 0, '0, 1, sel, be, wd);
  endtask

  task automatic check_regs(input string tag);
    reg_sel = 1'b0;
    tick();
    chk({tag, " cons reg"}, reg_rdata, {16'(exp_cons[1]), 16'(exp_cons[0])});
    chk({tag, " R9 pending"}, 32'(pending),
        32'((exp_cons[0] != exp_prod[0]) || (exp_cons[1] != exp_prod[1])));
    chk({tag, " R5 rx_ovf"}, 32'(rx_ovf), 32'(exp_ovf[0]));
    chk({tag, " R5 tx_ovf"}, 32'(tx_ovf), 32'(exp_ovf[1]));
    reg_sel = 1'b1;
    tick();
    chk({tag, " prod reg"}, reg_rdata, {16'(exp_prod[1]), 16'(exp_prod[0])});
    reg_sel = 1'b0;
  endtask

  task automatic check_entry(input string tag, input int ring, input int idx);
    ent_rd_en = 1'b1; ent_rd_ring = ring[0]; ent_rd_idx = idx[2:0];
    tick();
    ent_rd_en = 1'b0;
    chk({tag, " R10 entry"}, ent_rd_data, exp_mem[ring][idx]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_regs("R1 reset");

    // fill sweep: every level from empty up to one refused post per ring
    for (int n = 0; n <= D; n++) begin
      do_reset();
      for (int i = 0; i < n; i++)
        step(1, i[0], 15'(n * 37 + i * 1001), 16'(i * 3 + n * 256), 1, ~i[0],
             13'(i * 5 + n * 600), 0, 0, 2'b00, '0);
      check_regs("R4 fill");
      for (int i = 0; i < n && i < D - 1; i++) begin
        check_entry("R6 rx", 0, i);
        check_entry("R7 tx", 1, i);
      end
      // rx-only consumer write; high bits of the half must be dropped (R2)
      wreg(0, 2'b01, {16'hABCD, 16'(n + 8 * 5)});
      check_regs("R3 R2 half write");
      wreg(1, 2'b10, {16'(n + 3), 16'h5555});
      check_regs("R3 tx prod half write");
    end

    // wrap of both indexes
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 1, 15'(i), 16'(i), 1, 1, 13'(i), 0, 0, 2'b00, '0);
    wreg(0, 2'b11, {16'd5, 16'd5});
    for (int i = 0; i < 6; i++)
      step(1, 0, 15'(100 + i), 16'(200 + i), 1, 1, 13'(8000 + i), 0, 0, 2'b00, '0);
    check_regs("R4 wrap");
    for (int i = 5; i < 11; i++) begin
      check_entry("R6 wrap rx", 0, i % D);
      check_entry("R7 wrap tx", 1, i % D);
    end

    // same-cycle post and consumer write
    step(1, 1, 15'h7FFF, 16'hFFFF, 1, 1, 13'h1FFF, 1, 0, 2'b11, {16'd2, 16'd1});
    check_regs("R8 post+cons");
    check_entry("R8 rx entry", 0, 3);
    check_entry("R8 tx entry", 1, 3);
    // producer write wins over a post to the same ring
    step(1, 1, 15'd9, 16'd9, 0, 0, '0, 1, 1, 2'b01, {16'd0, 16'd6});
    check_regs("R8 prod wins");

    // drain both rings to empty
    wreg(0, 2'b11, 32'd0);
    wreg(1, 2'b11, 32'd0);
    check_regs("R11 zero");
    chk("R11 pending low", 32'(pending), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule